// File: doc/BRIEF.md
# Self-clocked addressed nibble receiver

This block listens to one serial wire that carries no clock and turns the traffic addressed to it into an 8-bit parallel output register. The wire rests high. Each frame opens with a low start bit and then a high start bit. The receiver counts how many system clocks the low start bit lasts and uses that count as the bit period for the rest of that frame. It samples each later bit at its midpoint. Three address bits in the frame are compared with three strap inputs, so up to eight receivers can share one wire. Each frame carries one nibble. Two matching frames in a row form one byte: the first supplies the low half and the second the high half.

A status line is normally high. It drops for one bit period when a byte has been written to the output. After reset, or after the receiver has lost track of the frame pairing, it waits for a long high stretch on the wire before it trusts the next falling edge as the start of a low-nibble frame. Malformed frames, a second frame with another address, and an overlong wait for the second frame all drop the half-built byte and force a new wait for that long high stretch.

No data flows in through a handshake. The output is a held register, so it has no valid/ready pair and cannot apply back-pressure. The sender sets the pace, and a new byte simply overwrites the register. The strap inputs are expected to be static.

Top module: `selfclk_nibble_rx`

## Requirements
- R1: After reset, par_out is 0x00 and ack_n is 1, and they stay so while the line rests high.
- R2: The bit period P is the number of clocks the synchronized line stays low in the first start bit. Counting the first high clock of the second start bit as clock 0, bit k is sampled at clock k*P + floor(P/2). The bits come in this order: k=1..3 are the address, least significant first; k=4..7 are the data nibble, least significant first; k=8 is the stop bit, which must be high.
- R3: A frame whose 3 address bits differ from strap changes neither par_out nor ack_n and leaves the pairing as it was.
- R4: The first matching frame of a pair gives par_out[3:0] and the second gives par_out[7:4]. par_out changes only on the second frame, exactly 3 clocks after the clock on which line_in carries that frame's stop-bit sample.
- R5: ack_n goes low in the same cycle that par_out is updated and stays low for exactly P clocks, where P is the second frame's period.
- R6: While out of sync, a frame is taken as a low-nibble frame only if the line was high for at least 20*P sampled clocks before its falling edge, counted from after the last frame's stop sample, with P being that frame's own period. Otherwise the frame is ignored.
- R7: A frame whose stop bit samples low is discarded, drops any pending low nibble and puts the receiver out of sync. The receiver then waits for the line to return high before it looks for a start bit.
- R8: A second frame that is well formed but carries a different address drops the pending nibble and puts the receiver out of sync.
- R9: If the second frame's stop sample has not arrived 40*P1 clocks after the first frame's stop sample (P1 is the first frame's period), the pending nibble is dropped and the receiver goes out of sync. If the stop sample lands exactly at 40*P1, the byte is accepted.
- R10: A low start bit shorter than 4 clocks counts as a malformed frame and puts the receiver out of sync.
- R11: After an accepted byte, the next matching frame is a low-nibble frame, with no idle stretch required.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Serial wire, rests high, asynchronous to clk |
| strap | input | 3 | Address this receiver answers to |
| par_out | output | 8 | Parallel output register |
| ack_n | output | 1 | Low for one bit period after a byte is accepted |

## Verification
The expiry of the second-frame timeout and the completion of the second frame can land in the same cycle. The bench provokes this by leaving exactly 30 bit periods of high line between two frames of period 8, so that the second stop sample falls 40 periods after the first. The reference model expects the frame to win, so the byte is accepted. The same pattern with one more idle clock must instead drop the nibble, after which the late frame is treated as a fresh low nibble. Every clock is compared against a behavioural model that decodes the whole stimulus from the sample list.

// File: rtl/nibrx_pkg.sv
package nibrx_pkg;
  localparam int ADDR_W = 3;
  localparam int NIB_W  = 4;
  localparam int FIELD_BITS = ADDR_W + NIB_W;

  typedef enum logic [1:0] {FR_IDLE, FR_MEAS, FR_SHIFT, FR_RECOVER} fr_state_e;
  typedef enum logic [1:0] {PR_HUNT, PR_FIRST, PR_SECOND} pr_state_e;

  typedef struct packed {
    logic              good;
    logic              longidle;
    logic [ADDR_W-1:0] addr;
    logic [NIB_W-1:0]  nib;
  } frame_s;
endpackage

// File: rtl/nibrx_sync.sv
module nibrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  // Rests high: reset to the idle level of the wire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/nibrx_framer.sv
module nibrx_framer import nibrx_pkg::*; #(
  parameter int PER_W      = 12,
  parameter int MIN_PERIOD = 4,
  parameter int SYNC_BITS  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             fr_valid,
  output frame_s           fr,
  output logic [PER_W-1:0] fr_per
);
  localparam int IDLE_W = PER_W + $clog2(SYNC_BITS) + 2;
  localparam int LAST_BIT = FIELD_BITS + 1;
  localparam logic [PER_W:0] CNT_MAX = {1'b0, {PER_W{1'b1}}};
  localparam logic [PER_W:0] MIN_P   = (PER_W+1)'(MIN_PERIOD);

  fr_state_e            st;
  logic [PER_W:0]       cnt;
  logic [PER_W:0]       target;
  logic [PER_W-1:0]     per;
  logic [3:0]           bit_idx;
  logic [FIELD_BITS-1:0] shreg;
  logic [IDLE_W-1:0]    idle_cnt;
  logic [IDLE_W-1:0]    idle_run;
  logic [IDLE_W-1:0]    idle_need;
  logic                 long_flag;

  assign idle_need = IDLE_W'(cnt) * IDLE_W'(SYNC_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_IDLE;
      cnt       <= '0;
      target    <= '0;
      per       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      idle_cnt  <= '0;
      idle_run  <= '0;
      long_flag <= 1'b0;
      fr_valid  <= 1'b0;
      fr        <= '0;
      fr_per    <= '0;
    end else begin
      fr_valid <= 1'b0;
      unique case (st)
        FR_IDLE: begin
          if (rx) begin
            if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
          end else begin
            idle_run <= idle_cnt;
            idle_cnt <= '0;
            cnt      <= (PER_W+1)'(1);
            st       <= FR_MEAS;
          end
        end
        FR_MEAS: begin
          if (!rx) begin
            if (cnt == CNT_MAX) begin
              fr_valid <= 1'b1;
              fr       <= '0;
              fr_per   <= per;
              st       <= FR_RECOVER;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt < MIN_P) begin
            fr_valid <= 1'b1;
            fr       <= '0;
            fr_per   <= per;
            st       <= FR_IDLE;
          end else begin
            per       <= cnt[PER_W-1:0];
            long_flag <= (idle_run >= idle_need);
            target    <= cnt + (cnt >> 1);
            cnt       <= (PER_W+1)'(1);
            bit_idx   <= 4'd1;
            st        <= FR_SHIFT;
          end
        end
        FR_SHIFT: begin
          if (cnt == target) begin
            cnt     <= (PER_W+1)'(1);
            target  <= {1'b0, per};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 4'(LAST_BIT)) begin
              fr_valid    <= 1'b1;
              fr.good     <= rx;
              fr.longidle <= long_flag;
              fr.addr     <= shreg[ADDR_W-1:0];
              fr.nib      <= shreg[FIELD_BITS-1:ADDR_W];
              fr_per      <= per;
              st          <= rx ? FR_IDLE : FR_RECOVER;
            end else begin
              shreg <= {rx, shreg[FIELD_BITS-1:1]};
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        FR_RECOVER: begin
          if (rx) st <= FR_IDLE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end

  // R2: a frame report is a single-cycle event
  assert_frame_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |=> !fr_valid);

  // R10: sampling never runs with a period below the floor
  assert_period_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_SHIFT) |-> (per >= MIN_P[PER_W-1:0]));
endmodule

// File: rtl/nibrx_pair.sv
module nibrx_pair import nibrx_pkg::*; #(
  parameter int PER_W        = 12,
  parameter int TIMEOUT_BITS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fr_valid,
  input  frame_s               fr,
  input  logic [PER_W-1:0]     fr_per,
  input  logic [ADDR_W-1:0]    strap,
  output logic [2*NIB_W-1:0]   par_out,
  output logic                 ack_n
);
  localparam int TO_W = PER_W + $clog2(TIMEOUT_BITS) + 2;

  pr_state_e        st;
  logic [NIB_W-1:0] lo_nib;
  logic [TO_W-1:0]  tcnt;
  logic [TO_W-1:0]  tlim;
  logic [PER_W-1:0] ack_cnt;
  logic             hit;

  assign hit   = (fr.addr == strap);
  assign ack_n = (ack_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PR_HUNT;
      lo_nib  <= '0;
      tcnt    <= '0;
      tlim    <= '0;
      ack_cnt <= '0;
      par_out <= '0;
    end else begin
      if (ack_cnt != '0) ack_cnt <= ack_cnt - 1'b1;
      if (fr_valid) begin
        if (!fr.good) begin
          st <= PR_HUNT;
        end else begin
          unique case (st)
            PR_HUNT, PR_FIRST: begin
              if (st == PR_FIRST || fr.longidle) begin
                if (hit) begin
                  lo_nib <= fr.nib;
                  tcnt   <= '0;
                  tlim   <= TO_W'(fr_per) * TO_W'(TIMEOUT_BITS);
                  st     <= PR_SECOND;
                end else begin
                  st <= PR_FIRST;
                end
              end
            end
            PR_SECOND: begin
              if (hit) begin
                par_out <= {fr.nib, lo_nib};
                ack_cnt <= fr_per;
                st      <= PR_FIRST;
              end else begin
                st <= PR_HUNT;
              end
            end
            default: st <= PR_HUNT;
          endcase
        end
      end else if (st == PR_SECOND) begin
        if (tcnt == tlim - 1'b1) st <= PR_HUNT;
        else                     tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R4: the output register only moves together with a status pulse
  assert_out_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_out) |-> !ack_n);

  // R7: a malformed frame always ends in the out-of-sync state
  assert_bad_frame_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr.good) |=> (st == PR_HUNT));

  // R9: the wait counter never passes its limit
  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PR_SECOND) |-> (tcnt < tlim));
endmodule

// File: rtl/selfclk_nibble_rx.sv
module selfclk_nibble_rx import nibrx_pkg::*; #(
  parameter int PER_W        = 12,
  parameter int MIN_PERIOD   = 4,
  parameter int SYNC_BITS    = 20,
  parameter int TIMEOUT_BITS = 40,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  input  logic [ADDR_W-1:0]  strap,
  output logic [2*NIB_W-1:0] par_out,
  output logic               ack_n
);
  logic             rx;
  logic             fr_valid;
  frame_s           fr;
  logic [PER_W-1:0] fr_per;

  nibrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_in),
    .dout (rx)
  );

  nibrx_framer #(
    .PER_W     (PER_W),
    .MIN_PERIOD(MIN_PERIOD),
    .SYNC_BITS (SYNC_BITS)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx      (rx),
    .fr_valid(fr_valid),
    .fr      (fr),
    .fr_per  (fr_per)
  );

  nibrx_pair #(
    .PER_W       (PER_W),
    .TIMEOUT_BITS(TIMEOUT_BITS)
  ) u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .fr_valid(fr_valid),
    .fr      (fr),
    .fr_per  (fr_per),
    .strap   (strap),
    .par_out (par_out),
    .ack_n   (ack_n)
  );
endmodule

// File: tb/selfclk_nibble_rx_test.sv
module selfclk_nibble_rx_test;
  localparam int MINP  = 4;
  localparam int SYNCB = 20;
  localparam int TOB   = 40;
  localparam int STRAP = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b1;
  logic [2:0] strap = 3'(STRAP);
  logic [7:0] par_out;
  logic       ack_n;

  always #5 clk = ~clk;

  selfclk_nibble_rx uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .strap(strap),
    .par_out(par_out), .ack_n(ack_n)
  );

  bit    wave[$];
  int    mk_idx[$];
  string mk_tag[$];
  int    ck_idx[$];
  int    ck_val[$];
  string ck_tag[$];
  int    ev_idx[$], ev_good[$], ev_addr[$], ev_nib[$], ev_long[$], ev_per[$];
  int    exp_par[$], exp_ack[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  task automatic mark(string t);
    mk_idx.push_back(wave.size()); mk_tag.push_back(t);
  endtask

  task automatic hold(int n, bit v);
    for (int i = 0; i < n; i++) wave.push_back(v);
  endtask

  task automatic frame(int p, int addr, int nib, bit stop_ok);
    hold(p, 1'b0); hold(p, 1'b1);
    for (int b = 0; b < 3; b++) hold(p, addr[b]);
    for (int b = 0; b < 4; b++) hold(p, nib[b]);
    hold(p, stop_ok);
  endtask

  task automatic pair(int p, int addr, int bv, int gap);
    frame(p, addr, bv & 15, 1'b1); hold(gap, 1'b1); frame(p, addr, (bv >> 4) & 15, 1'b1);
  endtask

  // Output after edge k reflects line sample k-3.
  task automatic expect_byte(int v, string t);
    ck_idx.push_back(wave.size() + 3); ck_val.push_back(v); ck_tag.push_back(t);
  endtask

  // Decode the whole sample list into frame events.
  function automatic void find_frames();
    int n = 0, idle = 2, lows, h, last, addr, nib, stp;
    int N = wave.size();
    while (n < N) begin
      if (wave[n]) begin idle++; n++; end
      else begin
        lows = 0;
        while (n < N && !wave[n]) begin lows++; n++; end
        if (n >= N) break;
        h = n;
        if (lows < MINP) begin
          ev_idx.push_back(h); ev_good.push_back(0); ev_addr.push_back(0);
          ev_nib.push_back(0); ev_long.push_back(0); ev_per.push_back(lows);
          idle = 0; n = h + 1;
        end else begin
          last = h + 8 * lows + lows / 2;
          if (last >= N) break;
          addr = 0; nib = 0;
          for (int k = 1; k <= 3; k++) addr |= int'(wave[h + k*lows + lows/2]) << (k-1);
          for (int k = 4; k <= 7; k++) nib  |= int'(wave[h + k*lows + lows/2]) << (k-4);
          stp = int'(wave[last]);
          ev_idx.push_back(last); ev_good.push_back(stp); ev_addr.push_back(addr);
          ev_nib.push_back(nib); ev_long.push_back(idle >= SYNCB * lows ? 1 : 0);
          ev_per.push_back(lows);
          n = last + 1; idle = 0;
          if (stp == 0) begin
            while (n < N && !wave[n]) n++;
            n++;
          end
        end
      end
    end
  endfunction

  // Walk the samples and fill the expected outputs (0 hunt, 1 first, 2 second).
  function automatic void model_outputs();
    int st = 0, par = 0, lo = 0, i1 = 0, p1 = 0, ackrem = 0, ei = 0;
    bit hit;
    for (int n = 0; n < wave.size(); n++) begin
      if (ei < ev_idx.size() && ev_idx[ei] == n) begin
        hit = (ev_addr[ei] == STRAP);
        if (ev_good[ei] == 0) st = 0;
        else if (st == 2) begin
          if (hit) begin par = ev_nib[ei] * 16 + lo; ackrem = ev_per[ei]; st = 1; end
          else st = 0;
        end else if (st == 1 || ev_long[ei] != 0) begin
          if (hit) begin lo = ev_nib[ei]; i1 = n; p1 = ev_per[ei]; st = 2; end
          else st = 1;
        end
        ei++;
      end else if (st == 2 && n == i1 + TOB * p1) st = 0;
      exp_par.push_back(par);
      exp_ack.push_back(ackrem == 0 ? 1 : 0);
      if (ackrem > 0) ackrem--;
    end
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int mi = 0, ci = 0, ep, ea;
    string tag;
    mark("R1");  hold(300, 1'b1); expect_byte(8'h00, "R1");
    mark("R2");  pair(8, STRAP, 8'h3A, 0); expect_byte(8'h3A, "R4"); hold(60, 1'b1);
    mark("R11"); pair(10, STRAP, 8'hC5, 3); expect_byte(8'hC5, "R11"); hold(3, 1'b1);
    pair(6, STRAP, 8'h4E, 0); expect_byte(8'h4E, "R11"); hold(40, 1'b1);
    mark("R3");  pair(8, 2, 8'hFF, 0); expect_byte(8'h4E, "R3"); hold(20, 1'b1);
    pair(13, STRAP, 8'h71, 0); expect_byte(8'h71, "R3"); hold(40, 1'b1);
    mark("R7");  frame(8, STRAP, 9, 1'b1); frame(8, STRAP, 2, 1'b0); expect_byte(8'h71, "R7");
    hold(30, 1'b1); pair(8, STRAP, 8'hAA, 0); expect_byte(8'h71, "R7");
    hold(200, 1'b1); pair(8, STRAP, 8'h5B, 0); expect_byte(8'h5B, "R7"); hold(20, 1'b1);
    mark("R6");  frame(8, STRAP, 1, 1'b0); hold(160, 1'b1); pair(8, STRAP, 8'h66, 0);
    expect_byte(8'h5B, "R6");
    frame(8, STRAP, 2, 1'b0); hold(161, 1'b1); pair(8, STRAP, 8'h99, 0);
    expect_byte(8'h99, "R6"); hold(20, 1'b1);
    mark("R8");  frame(8, STRAP, 3, 1'b1); frame(8, 6, 4, 1'b1); expect_byte(8'h99, "R8");
    hold(40, 1'b1); pair(8, STRAP, 8'h12, 0); expect_byte(8'h99, "R8");
    hold(200, 1'b1); pair(8, STRAP, 8'h34, 0); expect_byte(8'h34, "R8"); hold(20, 1'b1);
    mark("R9");  frame(8, STRAP, 7, 1'b1); hold(240, 1'b1); frame(8, STRAP, 14, 1'b1);
    expect_byte(8'hE7, "R9"); hold(20, 1'b1);
    frame(8, STRAP, 1, 1'b1); hold(241, 1'b1); frame(8, STRAP, 2, 1'b1);
    expect_byte(8'hE7, "R9"); frame(8, STRAP, 3, 1'b1); expect_byte(8'h32, "R9"); hold(20, 1'b1);
    mark("R10"); hold(2, 1'b0); hold(40, 1'b1); pair(8, STRAP, 8'h77, 0); expect_byte(8'h32, "R10");
    hold(200, 1'b1); pair(8, STRAP, 8'h88, 0); expect_byte(8'h88, "R10"); hold(20, 1'b1);
    mark("R5");  pair(5, STRAP, 8'hD4, 0); expect_byte(8'hD4, "R5"); hold(20, 1'b1);
    pair(4, STRAP, 8'h0F, 0); expect_byte(8'h0F, "R2"); hold(60, 1'b1);

    find_frames();
    model_outputs();

    rst_n = 1'b0; line_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (par_out !== 8'h00 || ack_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state: par_out=%h ack_n=%b expected 00 1", par_out, ack_n);
    end
    rst_n = 1'b1;
    for (int k = 0; k < wave.size(); k++) begin
      line_in = wave[k];
      @(posedge clk);
      @(negedge clk);
      ep = (k >= 3) ? exp_par[k-3] : 0;
      ea = (k >= 3) ? exp_ack[k-3] : 1;
      while (mi + 1 < mk_idx.size() && mk_idx[mi+1] <= k - 3) mi++;
      tag = mk_tag[mi];
      checks++;
      if (par_out !== 8'(ep) || ack_n !== 1'(ea)) begin
        errors++;
        $display("FAIL %s clock %0d: par_out=%h ack_n=%b expected %h %0d", tag, k, par_out, ack_n, ep, ea);
      end
      if (ci < ck_idx.size() && ck_idx[ci] == k) begin
        checks++;
        if (par_out !== 8'(ck_val[ci])) begin
          errors++;
          $display("FAIL %s byte at clock %0d: par_out=%h expected %h", ck_tag[ci], k, par_out, ck_val[ci]);
        end
        ci++;
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run still busy, expected completion");
      summary();
      $finish;
    end
  end
endmodule